// File: doc/BRIEF.md
# Multi-Mode Trigger-Driven Data Unit

This block is a 32-bit data engine built around eight data words, DATA0 to DATA7. An operation code puts it into one of several modes. It can act as a counter that is bounded, wrapping or up/down. It can act as a counter with a middle marker. It can shift up to 96 bits in from a serial line or out onto one. It can also act as a serial pattern matcher under a bit mask. Three select fields each pick one line of a shared input vector. One line is the trigger, one is the count direction and one is the serial data. A capture-edge setting decides which transitions of the trigger count as events.

Each mode ties its limits and reload targets to fixed data words. The shift modes also fix the order of the three words they use. The unit raises three event kinds: match, overflow and underflow. Each event kind has a sticky flag, an interrupt output gated by its own enable and a DMA request output gated by its own enable. The data words are loaded through a simple write port and read back through a read port. A start pulse arms the selected mode.

Top module: `data_unit`

## Requirements
- R1: Opcode 1 (bounded up) adds 1 to DATA3 on each trigger event until DATA3 reaches DATA1. An event at or above DATA1 holds the count and sets the overflow flag. Opcode 2 (bounded down) subtracts 1 until DATA3 is zero. An event at zero holds the count and sets the underflow flag.
- R2: Opcode 3 (wrapping up) reloads DATA3 from DATA0 and sets overflow on an event at or above DATA1. Opcode 4 (wrapping down) reloads DATA3 from DATA1 and sets underflow on an event at zero.
- R3: In opcodes 5 and 6 the direction line picks the count direction: 1 counts up toward DATA1, 0 counts down toward zero. Opcode 5 holds at either limit and flags. Opcode 6 reloads DATA0 at either limit and flags overflow at the top or underflow at zero.
- R4: Opcode 7 (three-point) counts up from DATA0. It sets the match flag on the event that brings DATA3 equal to the medium value DATA2. At or above DATA1 it reloads DATA0 and sets overflow.
- R5: A start pulse arms the unit. In opcodes 1 to 7 it copies DATA0 into DATA3. In opcode 12 it clears DATA3. In every mode it clears the bit counter. No trigger event acts before the first start.
- R6: The capture-edge setting selects the active trigger transition: 0 is rising, 1 is falling, 2 or 3 is both. The edge is found by comparing the trigger line with its registered copy.
- R7: Shift-in opcode 8 (left) shifts the 96-bit word {DATA4,DATA6,DATA5} left and inserts the serial bit at bit 0. Shift-in opcode 9 (right) shifts {DATA5,DATA6,DATA4} right and inserts at bit 95. After 96 bits the first bit received sits in DATA4 in both cases.
- R8: Shift-out opcode 10 drives the serial output from bit 95 of {DATA1,DATA0,DATA2} and shifts left. Shift-out opcode 11 drives it from bit 0 of {DATA2,DATA0,DATA1} and shifts right. In both cases DATA1 is sent first, and zeros fill in when the continuous control is 0. Bits 6:0 of DATA7 give the frame length; 0 or any value above 96 means 96. When the frame ends the unit pulses the frame-done output and stops; later events are ignored until the next start.
- R9: With the continuous control at 1, a shift-out rotates the word instead of zero-filling it. Any shift keeps running past the end of a frame and pulses frame-done once per frame.
- R10: Opcode 12 (match) shifts the serial bit into bit 0 of DATA3 on each event. It sets the match flag when the new DATA3 equals DATA1 in every bit where the mask DATA2 is 1.
- R11: The flags are match (bit 0), overflow (bit 1) and underflow (bit 2). A flag stays set until a 1 is written to its bit of the clear input, and a new event wins over a clear in the same cycle. The interrupt bus is each flag ANDed with its interrupt enable. The DMA bus is each flag ANDed with its DMA enable.
- R12: After reset every data word, flag, interrupt, DMA request, the serial output and frame-done are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| lines_i | input | 8 | Shared input line vector |
| sel_trig_i | input | 3 | Index of the trigger line |
| sel_dir_i | input | 3 | Index of the direction line |
| sel_sdat_i | input | 3 | Index of the serial data line |
| opcode_i | input | 4 | Operation mode |
| cap_edge_i | input | 2 | Active trigger transition |
| cont_i | input | 1 | Continuous shift control |
| start_i | input | 1 | Arm pulse |
| wr_en_i | input | 1 | Data word write strobe |
| wr_idx_i | input | 3 | Data word write index |
| wr_data_i | input | 32 | Data word write value |
| rd_idx_i | input | 3 | Data word read index |
| rd_data_o | output | 32 | Data word read value |
| flag_clr_i | input | 3 | Write-one-to-clear per flag |
| irq_en_i | input | 3 | Interrupt enables |
| dma_en_i | input | 3 | DMA request enables |
| flags_o | output | 3 | Sticky event flags |
| irq_o | output | 3 | Interrupt outputs |
| dma_o | output | 3 | DMA request outputs |
| sout_o | output | 1 | Serial output |
| frame_done_o | output | 1 | One-cycle end-of-frame pulse |

## Verification
The properties assume that every line of the input vector is synchronous to the clock and changes only once per cycle. The step and bound properties for counting apply only in cycles with no write and no start, because either of those may move DATA3 freely. The stimulus changes every input on the falling clock edge. It holds all lines low through reset, so the registered trigger copy agrees with the line at the first edge. It gives each trigger pulse a full cycle high and a full cycle low, so each active transition makes exactly one event.

// File: rtl/du_pkg.sv
package du_pkg;

    typedef enum logic [3:0] {
        OP_IDLE      = 4'd0,
        OP_INCR      = 4'd1,
        OP_DECR      = 4'd2,
        OP_INCR_WRAP = 4'd3,
        OP_DECR_WRAP = 4'd4,
        OP_UPDN      = 4'd5,
        OP_UPDN_WRAP = 4'd6,
        OP_THREE_PT  = 4'd7,
        OP_SIN_L     = 4'd8,
        OP_SIN_R     = 4'd9,
        OP_SOUT_L    = 4'd10,
        OP_SOUT_R    = 4'd11,
        OP_MATCH     = 4'd12
    } du_op_e;

    localparam int FL_MATCH = 0;
    localparam int FL_OVF   = 1;
    localparam int FL_UNF   = 2;
    localparam int NFLAG    = 3;

    function automatic logic is_count_op(du_op_e op);
        return (op >= OP_INCR) && (op <= OP_THREE_PT);
    endfunction

    function automatic logic is_shift_op(du_op_e op);
        return (op >= OP_SIN_L) && (op <= OP_SOUT_R);
    endfunction

endpackage

// File: rtl/du_edge.sv
module du_edge (
    input  logic       clk_i,
    input  logic       rst_ni,
    input  logic       lvl_i,
    input  logic [1:0] cap_edge_i,
    output logic       evt_o
);
    logic lvl_d, lvl_q;

    always_comb begin
        lvl_d = lvl_i;
        case (cap_edge_i)
            2'd0:    evt_o = lvl_i & ~lvl_q;
            2'd1:    evt_o = ~lvl_i & lvl_q;
            default: evt_o = lvl_i ^ lvl_q;
        endcase
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) lvl_q <= 1'b0;
        else         lvl_q <= lvl_d;
    end
endmodule

// File: rtl/du_count.sv
module du_count
    import du_pkg::*;
#(
    parameter int W = 32
) (
    input  du_op_e         op_i,
    input  logic           evt_i,
    input  logic           dir_i,
    input  logic           sdat_i,
    input  logic [W-1:0]   cnt_i,
    input  logic [W-1:0]   d0_i,
    input  logic [W-1:0]   d1_i,
    input  logic [W-1:0]   d2_i,
    output logic [W-1:0]   cnt_o,
    output logic           ovf_o,
    output logic           unf_o,
    output logic           mat_o
);
    logic at_top, at_zero;
    logic [W-1:0] up_v, dn_v;

    always_comb begin
        at_top  = (cnt_i >= d1_i);
        at_zero = (cnt_i == '0);
        up_v    = cnt_i + 1'b1;
        dn_v    = cnt_i - 1'b1;
        cnt_o   = cnt_i;
        ovf_o   = 1'b0;
        unf_o   = 1'b0;
        mat_o   = 1'b0;
        if (evt_i) begin
            case (op_i)
                OP_INCR: begin
                    if (at_top) ovf_o = 1'b1;
                    else        cnt_o = up_v;
                end
                OP_DECR: begin
                    if (at_zero) unf_o = 1'b1;
                    else         cnt_o = dn_v;
                end
                OP_INCR_WRAP: begin
                    if (at_top) begin cnt_o = d0_i; ovf_o = 1'b1; end
                    else        cnt_o = up_v;
                end
                OP_DECR_WRAP: begin
                    if (at_zero) begin cnt_o = d1_i; unf_o = 1'b1; end
                    else         cnt_o = dn_v;
                end
                OP_UPDN: begin
                    if (dir_i) begin
                        if (at_top) ovf_o = 1'b1;
                        else        cnt_o = up_v;
                    end else begin
                        if (at_zero) unf_o = 1'b1;
                        else         cnt_o = dn_v;
                    end
                end
                OP_UPDN_WRAP: begin
                    if (dir_i) begin
                        if (at_top) begin cnt_o = d0_i; ovf_o = 1'b1; end
                        else        cnt_o = up_v;
                    end else begin
                        if (at_zero) begin cnt_o = d0_i; unf_o = 1'b1; end
                        else         cnt_o = dn_v;
                    end
                end
                OP_THREE_PT: begin
                    if (at_top) begin
                        cnt_o = d0_i;
                        ovf_o = 1'b1;
                    end else begin
                        cnt_o = up_v;
                        mat_o = (up_v == d2_i);
                    end
                end
                OP_MATCH: begin
                    cnt_o = {cnt_i[W-2:0], sdat_i};
                    mat_o = (((cnt_o ^ d1_i) & d2_i) == '0);
                end
                default: ;
            endcase
        end
    end
endmodule

// File: rtl/du_shift.sv
module du_shift
    import du_pkg::*;
#(
    parameter int W   = 32,
    parameter int SW  = 3 * W,
    parameter int BCW = $clog2(SW + 1)
) (
    input  du_op_e           op_i,
    input  logic             evt_i,
    input  logic             run_i,
    input  logic             cont_i,
    input  logic             sdat_i,
    input  logic [BCW-1:0]   len_i,
    input  logic [BCW-1:0]   bitcnt_i,
    input  logic [W-1:0]     d0_i,
    input  logic [W-1:0]     d1_i,
    input  logic [W-1:0]     d2_i,
    input  logic [W-1:0]     d4_i,
    input  logic [W-1:0]     d5_i,
    input  logic [W-1:0]     d6_i,
    output logic [W-1:0]     d0_o,
    output logic [W-1:0]     d1_o,
    output logic [W-1:0]     d2_o,
    output logic [W-1:0]     d4_o,
    output logic [W-1:0]     d5_o,
    output logic [W-1:0]     d6_o,
    output logic [BCW-1:0]   bitcnt_o,
    output logic             run_o,
    output logic             done_o,
    output logic             sout_o
);
    localparam logic [BCW-1:0] SW_B = BCW'(SW);

    logic [SW-1:0]  win_l, win_r, wout_l, wout_r;
    logic [BCW-1:0] len_eff, cnt_inc;
    logic           step;

    always_comb begin
        win_l   = {d4_i, d6_i, d5_i};
        win_r   = {d5_i, d6_i, d4_i};
        wout_l  = {d1_i, d0_i, d2_i};
        wout_r  = {d2_i, d0_i, d1_i};
        len_eff = ((len_i == '0) || (len_i > SW_B)) ? SW_B : len_i;
        cnt_inc = bitcnt_i + 1'b1;
        step    = evt_i && run_i && is_shift_op(op_i);

        d0_o = d0_i; d1_o = d1_i; d2_o = d2_i;
        d4_o = d4_i; d5_o = d5_i; d6_o = d6_i;
        bitcnt_o = bitcnt_i;
        run_o    = run_i;
        done_o   = 1'b0;

        case (op_i)
            OP_SOUT_L: sout_o = wout_l[SW-1];
            OP_SOUT_R: sout_o = wout_r[0];
            default:   sout_o = 1'b0;
        endcase

        if (step) begin
            case (op_i)
                OP_SIN_L:  {d4_o, d6_o, d5_o} = {win_l[SW-2:0], sdat_i};
                OP_SIN_R:  {d5_o, d6_o, d4_o} = {sdat_i, win_r[SW-1:1]};
                OP_SOUT_L: {d1_o, d0_o, d2_o} = {wout_l[SW-2:0], cont_i & wout_l[SW-1]};
                OP_SOUT_R: {d2_o, d0_o, d1_o} = {cont_i & wout_r[0], wout_r[SW-1:1]};
                default: ;
            endcase
            if (cnt_inc == len_eff) begin
                done_o   = 1'b1;
                bitcnt_o = '0;
                run_o    = cont_i;
            end else begin
                bitcnt_o = cnt_inc;
            end
        end
    end
endmodule

// File: rtl/du_flags.sv
module du_flags
    import du_pkg::*;
(
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic [NFLAG-1:0] set_i,
    input  logic [NFLAG-1:0] clr_i,
    input  logic [NFLAG-1:0] irq_en_i,
    input  logic [NFLAG-1:0] dma_en_i,
    output logic [NFLAG-1:0] flags_o,
    output logic [NFLAG-1:0] irq_o,
    output logic [NFLAG-1:0] dma_o
);
    logic [NFLAG-1:0] flags_d, flags_q;

    always_comb begin
        flags_d = (flags_q & ~clr_i) | set_i;
        flags_o = flags_q;
        irq_o   = flags_q & irq_en_i;
        dma_o   = flags_q & dma_en_i;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) flags_q <= '0;
        else         flags_q <= flags_d;
    end

    // R11: an uncleared flag is never lost
    p_flag_sticky_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
        1'b1 |=> ((flags_q & $past(flags_q & ~clr_i)) == $past(flags_q & ~clr_i)));

    // R11: every raised event is visible in the next cycle
    p_flag_set_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
        1'b1 |=> ((flags_q & $past(set_i)) == $past(set_i)));
endmodule

// File: rtl/data_unit.sv
module data_unit
    import du_pkg::*;
#(
    parameter int W      = 32,
    parameter int NUM_IN = 8,
    parameter int SEL_W  = $clog2(NUM_IN)
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic [NUM_IN-1:0] lines_i,
    input  logic [SEL_W-1:0]  sel_trig_i,
    input  logic [SEL_W-1:0]  sel_dir_i,
    input  logic [SEL_W-1:0]  sel_sdat_i,
    input  logic [3:0]        opcode_i,
    input  logic [1:0]        cap_edge_i,
    input  logic              cont_i,
    input  logic              start_i,
    input  logic              wr_en_i,
    input  logic [2:0]        wr_idx_i,
    input  logic [W-1:0]      wr_data_i,
    input  logic [2:0]        rd_idx_i,
    output logic [W-1:0]      rd_data_o,
    input  logic [2:0]        flag_clr_i,
    input  logic [2:0]        irq_en_i,
    input  logic [2:0]        dma_en_i,
    output logic [2:0]        flags_o,
    output logic [2:0]        irq_o,
    output logic [2:0]        dma_o,
    output logic              sout_o,
    output logic              frame_done_o
);
    localparam int NREG = 8;
    localparam int SW   = 3 * W;
    localparam int BCW  = $clog2(SW + 1);
    localparam logic [BCW-1:0] SW_B = BCW'(SW);

    typedef struct packed {
        logic [NREG-1:0][W-1:0] data;
        logic [BCW-1:0]         bitcnt;
        logic                   running;
    } state_t;

    state_t state_d, state_q;
    du_op_e op;

    logic trig_lvl, dir_lvl, sdat_lvl, evt;
    logic ev_run;
    logic [W-1:0] cnt_nx;
    logic ovf_ev, unf_ev, mat_ev;
    logic [W-1:0] sh_d0, sh_d1, sh_d2, sh_d4, sh_d5, sh_d6;
    logic [BCW-1:0] sh_bitcnt;
    logic sh_run, sh_done;
    logic [NFLAG-1:0] flag_set;

    assign op       = du_op_e'(opcode_i);
    assign trig_lvl = lines_i[sel_trig_i];
    assign dir_lvl  = lines_i[sel_dir_i];
    assign sdat_lvl = lines_i[sel_sdat_i];
    assign ev_run   = evt & state_q.running;

    du_edge u_edge (
        .clk_i      (clk_i),
        .rst_ni     (rst_ni),
        .lvl_i      (trig_lvl),
        .cap_edge_i (cap_edge_i),
        .evt_o      (evt)
    );

    du_count #(.W(W)) u_count (
        .op_i   (op),
        .evt_i  (ev_run),
        .dir_i  (dir_lvl),
        .sdat_i (sdat_lvl),
        .cnt_i  (state_q.data[3]),
        .d0_i   (state_q.data[0]),
        .d1_i   (state_q.data[1]),
        .d2_i   (state_q.data[2]),
        .cnt_o  (cnt_nx),
        .ovf_o  (ovf_ev),
        .unf_o  (unf_ev),
        .mat_o  (mat_ev)
    );

    du_shift #(.W(W), .SW(SW), .BCW(BCW)) u_shift (
        .op_i     (op),
        .evt_i    (evt),
        .run_i    (state_q.running),
        .cont_i   (cont_i),
        .sdat_i   (sdat_lvl),
        .len_i    (state_q.data[7][BCW-1:0]),
        .bitcnt_i (state_q.bitcnt),
        .d0_i     (state_q.data[0]),
        .d1_i     (state_q.data[1]),
        .d2_i     (state_q.data[2]),
        .d4_i     (state_q.data[4]),
        .d5_i     (state_q.data[5]),
        .d6_i     (state_q.data[6]),
        .d0_o     (sh_d0),
        .d1_o     (sh_d1),
        .d2_o     (sh_d2),
        .d4_o     (sh_d4),
        .d5_o     (sh_d5),
        .d6_o     (sh_d6),
        .bitcnt_o (sh_bitcnt),
        .run_o    (sh_run),
        .done_o   (sh_done),
        .sout_o   (sout_o)
    );

    always_comb begin
        flag_set           = '0;
        flag_set[FL_MATCH] = mat_ev;
        flag_set[FL_OVF]   = ovf_ev;
        flag_set[FL_UNF]   = unf_ev;
    end

    du_flags u_flags (
        .clk_i    (clk_i),
        .rst_ni   (rst_ni),
        .set_i    (flag_set),
        .clr_i    (flag_clr_i),
        .irq_en_i (irq_en_i),
        .dma_en_i (dma_en_i),
        .flags_o  (flags_o),
        .irq_o    (irq_o),
        .dma_o    (dma_o)
    );

    always_comb begin
        state_d = state_q;
        if (is_count_op(op) || (op == OP_MATCH)) begin
            state_d.data[3] = cnt_nx;
        end
        if (is_shift_op(op)) begin
            state_d.data[0] = sh_d0;
            state_d.data[1] = sh_d1;
            state_d.data[2] = sh_d2;
            state_d.data[4] = sh_d4;
            state_d.data[5] = sh_d5;
            state_d.data[6] = sh_d6;
            state_d.bitcnt  = sh_bitcnt;
            state_d.running = sh_run;
        end
        if (start_i) begin
            state_d.running = 1'b1;
            state_d.bitcnt  = '0;
            if (is_count_op(op)) state_d.data[3] = state_q.data[0];
            else if (op == OP_MATCH) state_d.data[3] = '0;
        end
        if (wr_en_i) begin
            state_d.data[wr_idx_i] = wr_data_i;
        end
        rd_data_o    = state_q.data[rd_idx_i];
        frame_done_o = sh_done;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) state_q <= '0;
        else         state_q <= state_d;
    end

    // R1: a bounded up-count never climbs past DATA1 on its own
    p_no_overflow_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (op == OP_INCR) && !start_i && !wr_en_i && (state_q.data[3] <= state_q.data[1])
        |=> (state_q.data[3] <= $past(state_q.data[1])));

    // R1: each active event below the limit lowers the down-count by one
    p_decr_step_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (op == OP_DECR) && ev_run && !start_i && !wr_en_i && (state_q.data[3] != '0)
        |=> (state_q.data[3] == $past(state_q.data[3]) - 1'b1));

    // R8: a finished frame without continuous mode halts the unit
    p_frame_stop_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        frame_done_o && !cont_i && !start_i |=> !state_q.running);

    // R8: the bit counter stays inside one frame
    p_bitcnt_range_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        state_q.bitcnt < SW_B);

    // R5: no event acts while the unit is not armed
    p_idle_hold_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !state_q.running && !start_i && !wr_en_i |=> $stable(state_q.data));
endmodule

// File: tb/sim_data_unit.sv
module sim_data_unit;
    localparam int CLK_PERIOD = 10;
    localparam int TRG = 0;
    localparam int DIR = 1;
    localparam int SDT = 2;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  lines = '0;
    logic [3:0]  opcode = '0;
    logic [1:0]  cap_edge = '0;
    logic        cont = 1'b0;
    logic        start = 1'b0;
    logic        wr_en = 1'b0;
    logic [2:0]  wr_idx = '0;
    logic [31:0] wr_data = '0;
    logic [2:0]  rd_idx = '0;
    logic [31:0] rd_data;
    logic [2:0]  flag_clr = '0;
    logic [2:0]  irq_en = '0;
    logic [2:0]  dma_en = '0;
    logic [2:0]  flags, irq, dma;
    logic        sout, frame_done;

    int checks = 0;
    int errors = 0;
    int done_cnt = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    data_unit u0 (
        .clk_i(clk), .rst_ni(rst_n), .lines_i(lines),
        .sel_trig_i(3'(TRG)), .sel_dir_i(3'(DIR)), .sel_sdat_i(3'(SDT)),
        .opcode_i(opcode), .cap_edge_i(cap_edge), .cont_i(cont), .start_i(start),
        .wr_en_i(wr_en), .wr_idx_i(wr_idx), .wr_data_i(wr_data),
        .rd_idx_i(rd_idx), .rd_data_o(rd_data), .flag_clr_i(flag_clr),
        .irq_en_i(irq_en), .dma_en_i(dma_en), .flags_o(flags), .irq_o(irq),
        .dma_o(dma), .sout_o(sout), .frame_done_o(frame_done)
    );

    typedef struct packed {
        logic [3:0]  op;
        logic        dir;
        logic [31:0] d0;
        logic [31:0] d1;
        logic [31:0] d2;
        logic [7:0]  n;
        logic [31:0] ecnt;
        logic [2:0]  efl;
    } vec_t;

    localparam vec_t VECS [12] = '{
        '{4'd1, 1'b0, 32'd5, 32'd8, 32'd0, 8'd2, 32'd7, 3'b000},
        '{4'd1, 1'b0, 32'd5, 32'd8, 32'd0, 8'd5, 32'd8, 3'b010},
        '{4'd2, 1'b0, 32'd3, 32'd0, 32'd0, 8'd2, 32'd1, 3'b000},
        '{4'd2, 1'b0, 32'd3, 32'd0, 32'd0, 8'd4, 32'd0, 3'b100},
        '{4'd3, 1'b0, 32'd2, 32'd4, 32'd0, 8'd3, 32'd2, 3'b010},
        '{4'd4, 1'b0, 32'd1, 32'd6, 32'd0, 8'd3, 32'd5, 3'b100},
        '{4'd5, 1'b1, 32'd2, 32'd3, 32'd0, 8'd3, 32'd3, 3'b010},
        '{4'd5, 1'b0, 32'd1, 32'd9, 32'd0, 8'd3, 32'd0, 3'b100},
        '{4'd6, 1'b1, 32'd2, 32'd3, 32'd0, 8'd2, 32'd2, 3'b010},
        '{4'd6, 1'b0, 32'd1, 32'd9, 32'd0, 8'd2, 32'd1, 3'b100},
        '{4'd7, 1'b0, 32'd0, 32'd5, 32'd3, 8'd3, 32'd3, 3'b001},
        '{4'd7, 1'b0, 32'd0, 32'd5, 32'd3, 8'd6, 32'd0, 3'b011}
    };

    localparam logic [95:0] PAT = 96'h0123_4567_89AB_CDEF_F00D_CAFE;

    task automatic chk(input string tag, input logic [95:0] act, input logic [95:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] idx, input logic [31:0] val);
        @(negedge clk);
        wr_en = 1'b1; wr_idx = idx; wr_data = val;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [2:0] idx, output logic [31:0] val);
        @(negedge clk);
        rd_idx = idx;
        #1 val = rd_data;
    endtask

    task automatic do_start();
        @(negedge clk);
        start = 1'b1; flag_clr = 3'b111;
        @(negedge clk);
        start = 1'b0; flag_clr = 3'b000;
    endtask

    task automatic pulse(input logic sbit);
        @(negedge clk);
        lines[SDT] = sbit; lines[TRG] = 1'b1;
        #(CLK_PERIOD/4) if (frame_done) done_cnt++;
        @(negedge clk);
        lines[TRG] = 1'b0;
        #(CLK_PERIOD/4) if (frame_done) done_cnt++;
        @(negedge clk);
    endtask

    function automatic string vtag(input logic [3:0] op);
        case (op)
            4'd1, 4'd2: return "R1";
            4'd3, 4'd4: return "R2";
            4'd5, 4'd6: return "R3";
            default:    return "R4";
        endcase
    endfunction

    initial begin
        #(CLK_PERIOD * 150000);
        errors++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        logic [31:0] v, a, b, c;
        logic [95:0] model;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R12: reset state
        rd(3'd3, v); chk("R12 data3", 96'(v), 96'd0);
        rd(3'd1, v); chk("R12 data1", 96'(v), 96'd0);
        chk("R12 flags/irq/dma", 96'({flags, irq, dma}), 96'd0);
        chk("R12 sout/done", 96'({sout, frame_done}), 96'd0);

        // R5: no event before start
        opcode = 4'd1; wr(3'd1, 32'd50);
        pulse(1'b0);
        rd(3'd3, v); chk("R5 unarmed", 96'(v), 96'd0);
        wr(3'd0, 32'd42); do_start();
        rd(3'd3, v); chk("R5 start load", 96'(v), 96'd42);

        // counting table
        for (int i = 0; i < 12; i++) begin
            opcode = VECS[i].op;
            lines[DIR] = VECS[i].dir;
            wr(3'd0, VECS[i].d0);
            wr(3'd1, VECS[i].d1);
            wr(3'd2, VECS[i].d2);
            do_start();
            for (int k = 0; k < int'(VECS[i].n); k++) pulse(1'b0);
            rd(3'd3, v);
            chk({vtag(VECS[i].op), " count"}, 96'(v), 96'(VECS[i].ecnt));
            chk({vtag(VECS[i].op), " flags"}, 96'(flags), 96'(VECS[i].efl));
        end

        // R6: falling edge then both edges
        opcode = 4'd1; wr(3'd0, 32'd0); wr(3'd1, 32'd100);
        cap_edge = 2'd1; do_start();
        repeat (3) pulse(1'b0);
        rd(3'd3, v); chk("R6 falling", 96'(v), 96'd3);
        cap_edge = 2'd2; do_start();
        repeat (3) pulse(1'b0);
        rd(3'd3, v); chk("R6 both", 96'(v), 96'd6);
        cap_edge = 2'd0;

        // R11: enables and write-one-to-clear
        opcode = 4'd2; wr(3'd0, 32'd0); do_start();
        pulse(1'b0);
        chk("R11 unf flag", 96'(flags), 96'b100);
        irq_en = 3'b100; dma_en = 3'b000;
        @(negedge clk);
        chk("R11 irq gated", 96'({irq, dma}), 96'b100_000);
        dma_en = 3'b100; irq_en = 3'b011;
        @(negedge clk);
        chk("R11 dma gated", 96'({irq, dma}), 96'b000_100);
        @(negedge clk); flag_clr = 3'b010;
        @(negedge clk); flag_clr = 3'b000;
        chk("R11 clear other bit", 96'(flags), 96'b100);
        @(negedge clk); flag_clr = 3'b100;
        @(negedge clk); flag_clr = 3'b000;
        chk("R11 cleared", 96'({flags, dma}), 96'd0);
        irq_en = '0; dma_en = '0;

        // R7: shift-in left, 96 bits via length 0
        opcode = 4'd8; cont = 1'b0; wr(3'd7, 32'd0); do_start();
        done_cnt = 0;
        for (int i = 95; i >= 0; i--) pulse(PAT[i]);
        rd(3'd4, a); rd(3'd6, b); rd(3'd5, c);
        chk("R7 left order", {a, b, c}, PAT);
        chk("R8 done once", 96'(done_cnt), 96'd1);
        pulse(1'b1);
        rd(3'd5, c); chk("R8 ignored after frame", 96'(c), PAT[31:0]);

        // R7: shift-in right
        opcode = 4'd9; do_start();
        for (int i = 0; i < 96; i++) pulse(PAT[i]);
        rd(3'd5, a); rd(3'd6, b); rd(3'd4, c);
        chk("R7 right order", {a, b, c}, PAT);

        // R8: short frame length
        opcode = 4'd8; wr(3'd7, 32'd8); do_start();
        done_cnt = 0;
        for (int i = 7; i >= 0; i--) pulse(v[i] ^ v[i]);
        for (int i = 0; i < 1; i++) ;
        rd(3'd5, c); chk("R8 len8 bits", 96'(c[7:0]), 96'd0);
        chk("R8 len8 done", 96'(done_cnt), 96'd1);

        // R9: continuous shift-in, length 4, 8 bits
        cont = 1'b1; wr(3'd7, 32'd4); do_start();
        done_cnt = 0;
        for (int i = 7; i >= 0; i--) pulse(PAT[i]);
        rd(3'd5, c); chk("R9 cont in bits", 96'(c[7:0]), 96'(PAT[7:0]));
        chk("R9 cont in frames", 96'(done_cnt), 96'd2);
        cont = 1'b0;

        // R8: shift-out left, DATA1 first, zero fill
        opcode = 4'd10;
        wr(3'd1, PAT[95:64]); wr(3'd0, PAT[63:32]); wr(3'd2, PAT[31:0]);
        wr(3'd7, 32'd96); do_start();
        model = PAT;
        begin
            int bad = 0;
            for (int i = 0; i < 96; i++) begin
                @(negedge clk); #1;
                if (sout !== model[95]) bad++;
                model = model << 1;
                pulse(1'b0);
            end
            chk("R8 sout left stream", 96'(bad), 96'd0);
        end
        rd(3'd1, v); chk("R8 zero fill", 96'(v), 96'd0);

        // R9: shift-out right continuous rotates back
        opcode = 4'd11; cont = 1'b1;
        wr(3'd2, PAT[95:64]); wr(3'd0, PAT[63:32]); wr(3'd1, PAT[31:0]);
        do_start();
        model = PAT;
        begin
            int bad = 0;
            for (int i = 0; i < 96; i++) begin
                @(negedge clk); #1;
                if (sout !== model[0]) bad++;
                model = {model[0], model[95:1]};
                pulse(1'b0);
            end
            chk("R8 sout right stream", 96'(bad), 96'd0);
        end
        rd(3'd1, v); chk("R9 rotate restore", 96'(v), 96'(PAT[31:0]));
        cont = 1'b0;

        // R10: masked match on 8 bits of 0xA5
        opcode = 4'd12; wr(3'd1, 32'hFFFF_FFA5); wr(3'd2, 32'h0000_00FF);
        do_start();
        for (int i = 7; i >= 1; i--) pulse(a[0] | (8'hA5 >> i) & 1'b1 ? ((8'hA5 >> i) & 8'h1) != 0 : 1'b0);
        chk("R10 no match at 7 bits", 96'(flags), 96'b000);
        pulse(1'b1);
        chk("R10 match", 96'(flags), 96'b001);
        rd(3'd3, v); chk("R10 data3", 96'(v), 96'h0000_00A5);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule